// File: doc/BRIEF.md
# Configurable-Format Serial Character Transmitter

This block turns one parallel character into an asynchronous serial frame on a single transmit line. A seven-bit line-format word sets the frame shape. It selects a data length of 5 to 8 bits, one or extended stop time, and a parity mode: none, odd, even, forced-one or forced-zero. It also carries a break bit that pulls the line low. Bit timing comes from an external enable that pulses at sixteen times the baud rate. Baud-rate division is not part of this block.

A character is offered with `valid_i`. It is taken on a clock edge where `ready_o` is high. At that edge the data and the format word are both captured, and they hold for the whole frame. The break bit is the exception. It acts on the line at once, both between frames and inside a frame, and it never changes frame timing.

Top module: `ser_frame_tx`

## Requirements
- R1: After reset, and with no character in flight, `txd_o` is 1, `ready_o` is 1 and `busy_o` is 0 (break bit clear).
- R2: A frame starts with one start bit at 0. Data bits follow, least significant first. Every start, data and parity bit lasts exactly 16 tick pulses.
- R3: Format bits [1:0] set the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper data bits are not sent.
- R4: With format bit 2 at 0, the stop time is 16 ticks at level 1. With bit 2 at 1 it is 24 ticks for a 5-bit length and 32 ticks for the other lengths.
- R5: With format bit 3 at 1, one parity bit goes after the last data bit and before the stop time. With bit 3 at 0 there is no parity bit.
- R6: With bit 3 at 1 and bit 5 at 0, bit 4 at 0 makes the number of ones across data and parity odd. Bit 4 at 1 makes that number even.
- R7: With bits 3 and 5 at 1, the parity bit is fixed: 1 when bit 4 is 0, and 0 when bit 4 is 1.
- R8: While format bit 6 is 1, `txd_o` is 0 in every state. Once bit 6 clears, the line shows its normal level again.
- R9: Format bits [5:0] and the data are captured on acceptance. Later changes to them do not affect the frame in flight. `ready_o` is 0 and `busy_o` is 1 from the acceptance edge until the last stop tick.
- R10: The frame advances only on clock edges where `tick_i` is 1. Without ticks, the line level and `ready_o` stay unchanged.
- R11: A character can be accepted while the break bit is set. Its frame timing is unchanged and the line stays at 0 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Enable pulse at 16x the bit rate |
| cfg_i | input | 7 | Format word: [1:0] length, [2] stop, [3] parity enable, [4] even, [5] forced parity, [6] break |
| data_i | input | 8 | Character to send |
| valid_i | input | 1 | Character offered |
| ready_o | output | 1 | Character can be taken this cycle |
| txd_o | output | 1 | Serial line, idles at 1 |
| busy_o | output | 1 | Frame in progress |

## Verification
Break forcing and character acceptance can land on the same clock edge. One frame is therefore offered with the break bit already set, so the capture of the format word and the line override happen together. The bench checks that the line is 0 at the middle of every bit and that the stop time and the return of `ready_o` fall on the same tick counts as in an unbroken frame. A second case raises and drops break while the line is idle. It checks that the line goes low and then returns to 1, with no frame started.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef struct packed {
    logic       brk;
    logic       stick;
    logic       even;
    logic       par_en;
    logic       stop_ext;
    logic [1:0] wlen;
  } line_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } tx_state_e;
endpackage

// File: rtl/ser_tx_parity.sv
module ser_tx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        wlen_i,
  input  logic              even_i,
  input  logic              stick_i,
  output logic              par_o
);
  logic [DATA_W-1:0] masked;
  logic              ones_odd;

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      masked[i] = data_i[i] && (i < 5 + int'(wlen_i));
    ones_odd = ^masked;
    if (stick_i) par_o = !even_i;
    else         par_o = even_i ? ones_odd : !ones_odd;
  end
endmodule

// File: rtl/ser_tx_bit_timer.sv
module ser_tx_bit_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = tick_i && (cnt_q == limit_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= done_o ? '0 : cnt_q + CNT_W'(1);
  end

  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < limit_i);
endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx
  import ser_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [6:0] cfg_i,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  output logic       ready_o,
  output logic       txd_o,
  output logic       busy_o
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT) + 1;
  localparam logic [CNT_W-1:0] T_FULL = CNT_W'(TICKS_PER_BIT);
  localparam logic [CNT_W-1:0] T_1P5  = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
  localparam logic [CNT_W-1:0] T_TWO  = CNT_W'(2 * TICKS_PER_BIT);

  line_cfg_t         cfg_in, cfg_q;
  tx_state_e         state_q;
  logic [DATA_W-1:0] shift_q;
  logic [IDX_W-1:0]  idx_q, last_idx;
  logic              par_q, par_new;
  logic              accept, done, line_bit;
  logic [CNT_W-1:0]  limit;

  assign cfg_in   = line_cfg_t'(cfg_i);
  assign ready_o  = (state_q == ST_IDLE);
  assign busy_o   = !ready_o;
  assign accept   = valid_i && ready_o;
  assign last_idx = IDX_W'(4) + IDX_W'(cfg_q.wlen);

  always_comb begin
    if (state_q != ST_STOP || !cfg_q.stop_ext) limit = T_FULL;
    else if (cfg_q.wlen == 2'b00)              limit = T_1P5;
    else                                       limit = T_TWO;
  end

  ser_tx_parity #(.DATA_W(DATA_W)) u_par (
    .data_i  (data_i[DATA_W-1:0]),
    .wlen_i  (cfg_in.wlen),
    .even_i  (cfg_in.even),
    .stick_i (cfg_in.stick),
    .par_o   (par_new)
  );

  ser_tx_bit_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .tick_i  (tick_i && busy_o),
    .limit_i (limit),
    .done_o  (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      shift_q <= '0;
      idx_q   <= '0;
      par_q   <= 1'b0;
    end else if (accept) begin
      state_q <= ST_START;
      cfg_q   <= cfg_in;
      shift_q <= data_i[DATA_W-1:0];
      idx_q   <= '0;
      par_q   <= par_new;
    end else if (done) begin
      unique case (state_q)
        ST_START: state_q <= ST_DATA;
        ST_DATA: begin
          shift_q <= shift_q >> 1;
          if (idx_q == last_idx) state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
          else                   idx_q   <= idx_q + IDX_W'(1);
        end
        ST_PAR:  state_q <= ST_STOP;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line_bit = 1'b0;
      ST_DATA:  line_bit = shift_q[0];
      ST_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end

  // break acts on the live format bit, not the captured one
  assign txd_o = line_bit && !cfg_in.brk;

  a_r9_accept_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> !ready_o && busy_o);
  a_r9_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !$rose(busy_o) |-> $stable(cfg_q));
  a_r2_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !txd_o);
  a_r10_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !tick_i |=> busy_o);
  a_r8_break_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i[6] |-> !txd_o);
endmodule

// File: tb/ser_frame_tx_test.sv
`timescale 1ns/1ps
module ser_frame_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       tick_en = 1'b1;
  logic [6:0] cfg = '0;
  logic [7:0] data = '0;
  logic       valid = 1'b0;
  logic       ready, txd, busy;
  logic [1:0] div = '0;
  int         checks = 0;
  int         errors = 0;
  bit         done_flag = 1'b0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    div  <= div + 2'd1;
    tick <= tick_en && (div == 2'd3);
  end

  ser_frame_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cfg_i(cfg),
    .data_i(data), .valid_i(valid), .ready_o(ready), .txd_o(txd), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic accept(input logic [6:0] c, input logic [7:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    cfg = c; data = d; valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
  endtask

  // full frame with expected line levels computed from the format word
  task automatic t_frame(input logic [6:0] c, input logic [7:0] d, input bit scramble);
    int len, ones, stop_t, n;
    bit brk, par;
    len  = 5 + int'(c[1:0]);
    brk  = c[6];
    ones = 0;
    for (int i = 0; i < len; i++) ones += d[i];
    if (c[5]) par = !c[4];
    else      par = c[4] ? ones[0] : !ones[0];
    stop_t = !c[2] ? 16 : (len == 5 ? 24 : 32);
    accept(c, d);
    check(!ready && busy, "R9 ready low after accept", ready, 0);
    if (scramble) begin
      cfg = c ^ 7'h3F;
      data = ~d;
    end
    wait_ticks(8);
    check(txd == 1'b0, "R2 start bit", txd, 0);
    wait_ticks(8);
    for (int i = 0; i < len; i++) begin
      wait_ticks(8);
      check(txd == (brk ? 1'b0 : d[i]), brk ? "R11 data under break" : "R3 data bit", txd, brk ? 0 : d[i]);
      wait_ticks(8);
    end
    if (c[3]) begin
      wait_ticks(8);
      check(txd == (brk ? 1'b0 : par), c[5] ? "R7 stick parity" : "R6 parity value", txd, brk ? 0 : par);
      wait_ticks(8);
    end
    wait_ticks(8);
    check(txd == !brk, c[3] ? "R5 stop after parity" : "R5 stop, no parity", txd, !brk);
    check(!ready, "R9 ready low in stop", ready, 0);
    n = 0;
    while (!ready && n < 100) begin
      wait_ticks(1);
      n++;
    end
    check(n == stop_t - 8, brk ? "R11 stop timing under break" : "R4 stop length", n + 8, stop_t);
    cfg = c;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(txd && ready && !busy, "R1 reset idle", {txd, ready, busy}, 3'b110);
  endtask

  task automatic t_idle_break;
    @(negedge clk);
    cfg = 7'h40;
    @(negedge clk);
    check(txd == 1'b0, "R8 break while idle", txd, 0);
    wait_ticks(40);
    check(txd == 1'b0 && ready, "R8 break holds, no frame", {txd, ready}, 2'b01);
    cfg = 7'h00;
    @(negedge clk);
    check(txd == 1'b1, "R8 line restored", txd, 1);
  endtask

  task automatic t_mid_break;
    accept(7'h03, 8'hFF);
    wait_ticks(24);
    check(txd == 1'b1, "R8 data bit before break", txd, 1);
    cfg = 7'h43;
    @(negedge clk);
    check(txd == 1'b0, "R8 break mid frame", txd, 0);
    cfg = 7'h03;
    @(negedge clk);
    check(txd == 1'b1, "R8 resume mid frame", txd, 1);
    while (!ready) @(negedge clk);
  endtask

  task automatic t_no_tick;
    accept(7'h03, 8'h01);
    wait_ticks(4);
    tick_en = 1'b0;
    repeat (60) @(negedge clk);
    check(txd == 1'b0 && busy, "R10 stall in start bit", {txd, busy}, 2'b01);
    tick_en = 1'b1;
    wait_ticks(12 + 8);
    check(txd == 1'b1, "R10 resumes to data bit 0", txd, 1);
    while (!ready) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_frame(7'b000_0011, 8'hA5, 1'b0);
    t_frame(7'b000_0000, 8'hF3, 1'b0);
    t_frame(7'b000_0100, 8'h15, 1'b0);
    t_frame(7'b000_0101, 8'h2A, 1'b0);
    t_frame(7'b000_1010, 8'h53, 1'b0);
    t_frame(7'b001_1111, 8'h81, 1'b0);
    t_frame(7'b001_1001, 8'h07, 1'b0);
    t_frame(7'b010_1011, 8'h00, 1'b0);
    t_frame(7'b011_1010, 8'h7F, 1'b0);
    t_frame(7'b000_1100, 8'h19, 1'b1);
    t_frame(7'b100_1111, 8'hC3, 1'b0);
    t_idle_break();
    t_mid_break();
    t_no_tick();
    t_reset();
    done_flag = 1'b1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule